// File: doc/BRIEF.md
# Split-Region Framebuffer Line Fetcher

This block reads a display's pixel lines out of byte-wide memory, one line for each line request. A frame has two regions. The upper rows come from a primary area and the lower rows come from a menu area. Each area has its own base address. A split count gives the number of rows taken from the primary area before fetching moves to the menu area. Each line is 17 consecutive bytes. The block reads them as one burst over a simple request/ready byte port and packs them into a 136-bit line word. A one-cycle strobe marks the line word as complete.

A frame-start pulse returns the row counter to the first row and loads the two base addresses and the split count from the inputs. Writes to those inputs between frame starts have no effect until the next frame start. The serializer that follows the block takes the line word when the strobe fires and shifts it out.

Top module: `fbf_line_fetch`

## Requirements
- R1: While reset is active and after it is released, `line_valid_o` and `mem_req_o` are low and `line_o` is all zeros until a fetch completes.
- R2: Each fetch issues exactly 17 byte reads. Their addresses are consecutive and ascending, starting at the line base. Read data arrives on `mem_rdata_i` in the cycle after a read is accepted (`mem_req_o` and `mem_ready_i` both high).
- R3: The byte read at line base + k lands in `line_o[8k+7:8k]`, so pixels packed least-significant-bit first map to ascending `line_o` bits. All eight bits of byte 16 are kept, including the five above the last visible column.
- R4: A row r below the split count is fetched from primary base + 17·r.
- R5: A row r at or above the split count is fetched from menu base + 17·(r − split). All address arithmetic wraps modulo 2^16.
- R6: With a split count of 0, every row comes from the menu area. With a split count of 64 or more (7-bit `split_rows_i`), every row comes from the primary area.
- R7: A frame-start pulse makes the next fetched row row 0. Each accepted request advances the row by one, and row 63 wraps to row 0.
- R8: The base addresses and the split count are sampled only on a frame-start pulse. A change between pulses does not affect the addresses fetched in the current frame.
- R9: `line_valid_o` is a single-cycle pulse, once per fetch, in the cycle `line_o` holds the complete line.
- R10: A line request that arrives while a fetch is in progress is ignored. It causes no extra reads, no extra strobe and no row advance.
- R11: While `mem_ready_i` is low, a pending read holds `mem_req_o` high with `mem_addr_o` unchanged.
- R12: With `mem_ready_i` held high, the 17 reads go out on consecutive cycles. `line_valid_o` rises 18 clock edges after the edge that samples the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Start of frame: loads the configuration and sets the row to 0 |
| line_req_i | input | 1 | Request to fetch the next line |
| primary_base_i | input | 16 | Byte address of row 0 of the primary area |
| menu_base_i | input | 16 | Byte address of the first menu row |
| split_rows_i | input | 7 | Number of rows taken from the primary area |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | 16 | Byte read address |
| mem_ready_i | input | 1 | Memory accepts the request in this cycle |
| mem_rdata_i | input | 8 | Read data, one cycle after acceptance |
| line_o | output | 136 | Assembled line, byte k at bits 8k+7:8k |
| line_valid_o | output | 1 | One-cycle strobe: line complete |

## Verification
The bound checker checks four things on every cycle: the strobe is a single-cycle pulse, consecutive accepted reads step the address by one, a stalled read holds its address, and exactly 17 reads are accepted before each strobe. Several properties depend on the frame's history, and only the bench's scenarios can show them: the choice of region for each row, the menu offset arithmetic, row wrap-around, configuration sampling at frame start, dropping of requests that arrive mid-fetch, and the packing of bytes into the line word. The bench covers these with several base and split settings, with and without memory stalls.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  localparam int unsigned FBF_ADDR_W     = 16;
  localparam int unsigned FBF_DATA_W     = 8;
  localparam int unsigned FBF_LINE_BYTES = 17;
  localparam int unsigned FBF_ROWS       = 64;

  typedef enum logic {
    FETCH_IDLE = 1'b0,
    FETCH_BUSY = 1'b1
  } fetch_state_e;
endpackage

// File: rtl/fbf_row_ctrl.sv
module fbf_row_ctrl #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned ROWS       = 64,
  parameter int unsigned LINE_BYTES = 17,
  localparam int unsigned ROW_W     = $clog2(ROWS),
  localparam int unsigned SPLIT_W   = ROW_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  primary_base_i,
  input  logic [ADDR_W-1:0]  menu_base_i,
  input  logic [SPLIT_W-1:0] split_rows_i,
  output logic [ADDR_W-1:0]  line_base_o
);
  logic [ADDR_W-1:0]  pbase_q, mbase_q;
  logic [SPLIT_W-1:0] split_q;
  logic [ROW_W-1:0]   row_q;

  logic [ADDR_W-1:0]  eff_pbase, eff_mbase, base_sel;
  logic [SPLIT_W-1:0] eff_split;
  logic [ROW_W-1:0]   eff_row, ofs_rows;
  logic               in_primary;

  // a request coinciding with frame start uses the fresh configuration at row 0
  always_comb begin
    eff_pbase  = frame_start_i ? primary_base_i : pbase_q;
    eff_mbase  = frame_start_i ? menu_base_i    : mbase_q;
    eff_split  = frame_start_i ? split_rows_i   : split_q;
    eff_row    = frame_start_i ? '0             : row_q;
    in_primary = {1'b0, eff_row} < eff_split;
    ofs_rows   = in_primary ? eff_row : eff_row - eff_split[ROW_W-1:0];
    base_sel   = in_primary ? eff_pbase : eff_mbase;
    line_base_o = base_sel + ADDR_W'(ofs_rows) * ADDR_W'(LINE_BYTES);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pbase_q <= '0;
      mbase_q <= '0;
      split_q <= '0;
      row_q   <= '0;
    end else begin
      if (frame_start_i) begin
        pbase_q <= primary_base_i;
        mbase_q <= menu_base_i;
        split_q <= split_rows_i;
      end
      if (start_i) begin
        row_q <= (eff_row == ROW_W'(ROWS - 1)) ? '0 : eff_row + 1'b1;
      end else if (frame_start_i) begin
        row_q <= '0;
      end
    end
  end
endmodule

// File: rtl/fbf_issue.sv
module fbf_issue #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned LINE_BYTES = 17,
  localparam int unsigned IDX_W     = $clog2(LINE_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] line_base_i,
  input  logic              mem_ready_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              accept_o
);
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  cnt_q;

  assign mem_req_o  = busy_i && (cnt_q < IDX_W'(LINE_BYTES));
  assign mem_addr_o = base_q + ADDR_W'(cnt_q);
  assign accept_o   = mem_req_o && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      base_q <= line_base_i;
      cnt_q  <= '0;
    end else if (accept_o) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fbf_capture.sv
module fbf_capture #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned LINE_BYTES = 17,
  localparam int unsigned IDX_W     = $clog2(LINE_BYTES + 1),
  localparam int unsigned LINE_W    = DATA_W * LINE_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              done_o,
  output logic [LINE_W-1:0] line_o,
  output logic              line_valid_o
);
  logic             pend_q;
  logic [IDX_W-1:0] idx_q;
  logic             valid_q;

  assign done_o       = pend_q && (idx_q == IDX_W'(LINE_BYTES - 1));
  assign line_valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      pend_q  <= accept_i;
      valid_q <= done_o;
      if (start_i)     idx_q <= '0;
      else if (pend_q) idx_q <= idx_q + 1'b1;
    end
  end

  for (genvar k = 0; k < LINE_BYTES; k++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                byte_q <= '0;
      else if (pend_q && idx_q == IDX_W'(k))      byte_q <= rdata_i;
    end
    assign line_o[k*DATA_W +: DATA_W] = byte_q;
  end
endmodule

// File: rtl/fbf_line_fetch.sv
module fbf_line_fetch
  import fbf_pkg::*;
#(
  parameter int unsigned ADDR_W     = FBF_ADDR_W,
  parameter int unsigned DATA_W     = FBF_DATA_W,
  parameter int unsigned LINE_BYTES = FBF_LINE_BYTES,
  parameter int unsigned ROWS       = FBF_ROWS,
  localparam int unsigned SPLIT_W   = $clog2(ROWS) + 1,
  localparam int unsigned LINE_W    = DATA_W * LINE_BYTES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic               line_req_i,
  input  logic [ADDR_W-1:0]  primary_base_i,
  input  logic [ADDR_W-1:0]  menu_base_i,
  input  logic [SPLIT_W-1:0] split_rows_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_ready_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic [LINE_W-1:0]  line_o,
  output logic               line_valid_o
);
  fetch_state_e      state_q;
  logic              start, done, accept;
  logic [ADDR_W-1:0] line_base;

  assign start = line_req_i && (state_q == FETCH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= FETCH_IDLE;
    else if (start) state_q <= FETCH_BUSY;
    else if (done)  state_q <= FETCH_IDLE;
  end

  fbf_row_ctrl #(
    .ADDR_W(ADDR_W), .ROWS(ROWS), .LINE_BYTES(LINE_BYTES)
  ) u_row (
    .clk_i, .rst_ni, .frame_start_i,
    .start_i        (start),
    .primary_base_i, .menu_base_i, .split_rows_i,
    .line_base_o    (line_base)
  );

  fbf_issue #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
  ) u_issue (
    .clk_i, .rst_ni,
    .start_i     (start),
    .busy_i      (state_q == FETCH_BUSY),
    .line_base_i (line_base),
    .mem_ready_i,
    .mem_req_o,
    .mem_addr_o,
    .accept_o    (accept)
  );

  fbf_capture #(
    .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)
  ) u_cap (
    .clk_i, .rst_ni,
    .start_i      (start),
    .accept_i     (accept),
    .rdata_i      (mem_rdata_i),
    .done_o       (done),
    .line_o,
    .line_valid_o
  );
endmodule

// File: rtl/fbf_line_fetch_chk.sv
module fbf_line_fetch_chk #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned LINE_BYTES = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              line_valid_o
);
  logic [7:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           acc_q <= '0;
    else if (line_valid_o) acc_q <= {7'd0, mem_req_o && mem_ready_i};
    else if (mem_req_o && mem_ready_i) acc_q <= acc_q + 8'd1;
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |=> !line_valid_o);

  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i) |=> (!mem_req_o || mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));

  // R11
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R12
  burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> acc_q == 8'(LINE_BYTES));
endmodule

bind fbf_line_fetch fbf_line_fetch_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_o    (mem_req_o),
  .mem_ready_i  (mem_ready_i),
  .mem_addr_o   (mem_addr_o),
  .line_valid_o (line_valid_o)
);

// File: tb/fbf_line_fetch_test.sv
`timescale 1ns/1ps
module fbf_line_fetch_test;
  localparam int AW = 16, SW = 7, LW = 136;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          frame_start_i = 1'b0, line_req_i = 1'b0, mem_ready_i = 1'b1;
  logic [AW-1:0] primary_base_i = '0, menu_base_i = '0;
  logic [SW-1:0] split_rows_i = '0;
  logic          mem_req_o, line_valid_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_rdata_i = '0;
  logic [LW-1:0] line_o;

  int  errs = 0, checks = 0;
  bit  stall_en = 1'b0;
  logic [7:0] lfsr = 8'h01;

  // {primary, menu, split, stall}
  localparam logic [39:0] VEC [5] = '{
    {16'h1000, 16'h4000, 7'd64,  1'b0},
    {16'h1000, 16'h4000, 7'd0,   1'b0},
    {16'h0100, 16'h8000, 7'd56,  1'b0},
    {16'h2345, 16'h7001, 7'd1,   1'b1},
    {16'hFFF0, 16'h0003, 7'd100, 1'b1}
  };

  fbf_line_fetch uut (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [7:0] mem_val(input logic [AW-1:0] a);
    return a[7:0] * 8'd29 + a[15:8] + 8'h5A;
  endfunction

  always @(posedge clk_i) if (mem_req_o && mem_ready_i) mem_rdata_i <= mem_val(mem_addr_o);

  always @(negedge clk_i) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready_i = stall_en ? lfsr[0] : 1'b1;
  end

  function automatic logic [AW-1:0] row_addr(input logic [AW-1:0] pb, mb,
                                              input int split, r);
    if (r < split) return AW'(pb + AW'(r * 17));
    return AW'(mb + AW'((r - split) * 17));
  endfunction

  function automatic logic [LW-1:0] exp_line(input logic [AW-1:0] a);
    logic [LW-1:0] v;
    for (int k = 0; k < 17; k++) v[8*k +: 8] = mem_val(AW'(a + AW'(k)));
    return v;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame_start();
    @(negedge clk_i) frame_start_i = 1'b1;
    @(negedge clk_i) frame_start_i = 1'b0;
  endtask

  task automatic wait_valid(output int n);
    n = 1;
    while (!line_valid_o && n < 400) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic fetch(input logic [AW-1:0] a, input bit timed, input string req);
    int n;
    @(negedge clk_i) line_req_i = 1'b1;
    @(negedge clk_i) line_req_i = 1'b0;
    wait_valid(n);
    chk(line_valid_o == 1'b1, {req, " R9 strobe"}, LW'(line_valid_o), LW'(1));
    chk(line_o == exp_line(a), {req, " R2 R3 line"}, line_o, exp_line(a));
    if (timed) chk(n == 19, "R12 latency", LW'(n), LW'(19));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errs++; checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n, nv;
    repeat (3) @(negedge clk_i);
    // R1 during and after reset
    chk(!line_valid_o && !mem_req_o && line_o == '0, "R1 reset", {line_valid_o, mem_req_o, line_o[7:0]}, '0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!line_valid_o && !mem_req_o && line_o == '0, "R1 after reset", {line_valid_o, mem_req_o, line_o[7:0]}, '0);

    for (int v = 0; v < 5; v++) begin
      logic [AW-1:0] pb, mb;
      int sp;
      pb = VEC[v][39:24]; mb = VEC[v][23:8]; sp = int'(VEC[v][7:1]);
      primary_base_i = pb; menu_base_i = mb; split_rows_i = SW'(sp);
      stall_en = VEC[v][0];
      frame_start();
      // 65 rows: the last one checks R7 wrap to row 0
      for (int r = 0; r < 65; r++) begin
        string tag;
        tag = (sp == 0 || sp >= 64) ? "R6" : ((r % 64) < sp ? "R4" : "R5");
        if (r == 64) tag = "R7 wrap";
        fetch(row_addr(pb, mb, sp, r % 64), !VEC[v][0], tag);
      end
    end
    stall_en = 1'b0;

    // R8: config sampled only at frame start
    primary_base_i = 16'h0200; menu_base_i = 16'h0900; split_rows_i = 7'd3;
    frame_start();
    primary_base_i = 16'h5000; menu_base_i = 16'h6000; split_rows_i = 7'd0;
    for (int r = 0; r < 5; r++) fetch(row_addr(16'h0200, 16'h0900, 3, r), 1'b1, "R8 old cfg");
    frame_start();
    fetch(16'h6000, 1'b1, "R8 new cfg");

    // R7: frame start mid-frame returns to row 0
    fetch(16'h6011, 1'b1, "R7 row1");
    fetch(16'h6022, 1'b1, "R7 row2");
    frame_start();
    fetch(16'h6000, 1'b1, "R7 restart");

    // R3: top byte carries all eight bits
    chk(line_o[135:128] == mem_val(16'h6010), "R3 byte16", LW'(line_o[135:128]), LW'(mem_val(16'h6010)));

    // R10: request mid-fetch ignored
    @(negedge clk_i) line_req_i = 1'b1;
    @(negedge clk_i) line_req_i = 1'b0;
    repeat (4) @(negedge clk_i);
    line_req_i = 1'b1;
    @(negedge clk_i) line_req_i = 1'b0;
    wait_valid(n);
    chk(line_o == exp_line(16'h6011), "R10 first line", line_o, exp_line(16'h6011));
    nv = 0;
    repeat (30) begin
      @(negedge clk_i);
      if (line_valid_o) nv++;
    end
    chk(nv == 0, "R10 no second strobe", LW'(nv), LW'(0));
    chk(!mem_req_o, "R10 no extra reads", LW'(mem_req_o), LW'(0));
    fetch(16'h6022, 1'b1, "R10 row advanced once");

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule